// File: doc/BRIEF.md
# Frame-Timed Register-Write Sequencer

This block replays a short stored program of 16-bit words against its own free-running frame position counter, which steps once per clock (one clock is one quarter-bit step) through a frame of `FRAME_LEN` positions and then wraps. The program can do two things. It can hold until the frame position reaches an absolute value, or it can emit a one-cycle write strobe that carries a 7-bit peripheral register address and an 8-bit data byte. A word of all zeros ends the program.

Software loads the program through a simple write port while the sequencer is idle, then pulses `start`. The sequencer shows `busy` for the whole run and pulses `done` once the terminating word has been consumed. Hold targets are absolute frame positions, so a program can lay its writes out around fixed points in the frame and can carry on past the wrap into the next frame.

The control state machine has three states. `S_IDLE` waits for `start`. `S_RUN` decodes one word per step. `S_HOLD` stalls on an unmatched hold target. The transitions are:
- IDLE->RUN on `start`, with the program counter cleared.
- RUN->RUN on a move, or on a hold whose target already matches, with the program counter advanced.
- RUN->HOLD on a hold whose target does not match.
- HOLD->HOLD while the position differs from the target.
- HOLD->RUN when it matches, with the program counter advanced.
- RUN->IDLE on the zero word.

Top module: `qb_scenario_seq`

## Requirements
- R1: `frame_pos` is 0 after reset, rises by one every clock, and goes from `FRAME_LEN-1` (default 4999) back to 0.
- R2: A nonzero word with bit 15 set is a move. Bits 14:8 give the register address and bits 7:0 the data, and executing it raises `wr_en` for exactly one cycle with those values on `wr_addr` and `wr_data`.
- R3: A nonzero word with bit 15 clear is a hold. Bits 12:0 give the target and bits 14:13 are ignored, so a hold for position 0 is written 16'h2000. Execution stalls until `frame_pos` equals the target, and the next word is decoded in the following cycle.
- R4: When a word is decoded with `frame_pos` equal to p, its strobe or `done` pulse is visible while `frame_pos` is p+1. Consecutive moves strobe on consecutive steps, so the k-th move (k = 0, 1, ...) after a hold matched at T strobes at T+2+k.
- R5: The all-zero word ends the run. `done` is high for one cycle, `busy` is low from that same cycle onward, and no strobe coincides with `done`.
- R6: A hold whose target is below the position of the previous match is satisfied in the next frame. An example is a hold at 4998 followed by a hold at 63.
- R7: Consecutive holds for position 0 are each satisfied in turn, one full frame apart.
- R8: A program without a leading hold writes immediately. When `start` is sampled in the cycle where `frame_pos` is S, the first word is decoded at S+1 and its strobe appears at S+2.
- R9: Program-memory writes are taken only while `busy` is low. A write while busy leaves the stored program unchanged.
- R10: After reset, `busy`, `done` and `wr_en` are low, and `start` is acted on only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one quarter-bit step |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | AW | Program memory write address |
| prog_wdata | input | 16 | Program word to store |
| start | input | 1 | Begin the stored program at word 0 |
| frame_pos | output | CNT_W | Current frame position |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end-of-program pulse |
| wr_en | output | 1 | Peripheral register write strobe |
| wr_addr | output | 7 | Peripheral register address |
| wr_data | output | 8 | Peripheral register data |

## Verification
Every cycle, the assertions check the following properties:
- the frame position stays in range and steps or wraps;
- the program counter stays frozen during an unmatched hold;
- strobes appear only inside a run and never together with `done`;
- `done` marks the busy-to-idle edge;
- a locked write leaves the memory untouched.

Whether each strobe lands on the right frame position, whether holds across the wrap and repeated holds at 0 really wait a frame, and whether writes while busy leave a later replay unchanged can only be shown by the bench's scenarios. The bench compares those scenarios against a step-by-step timing model of the program.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    localparam int WORD_W = 16;
    localparam int TGT_W  = 13;
    localparam int RADR_W = 7;
    localparam int RDAT_W = 8;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_HOLD = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_END  = 2'd0,
        OP_HOLD = 2'd1,
        OP_MOVE = 2'd2
    } seq_op_t;

    function automatic seq_op_t classify(input logic [WORD_W-1:0] w);
        if (w == '0)
            return OP_END;
        else if (w[WORD_W-1])
            return OP_MOVE;
        else
            return OP_HOLD;
    endfunction
endpackage

// File: rtl/fseq_frame_ctr.sv
module fseq_frame_ctr #(
    parameter int FRAME_LEN = 5000,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] pos_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pos_q <= '0;
        else if (pos_q == LAST)
            pos_q <= '0;
        else
            pos_q <= pos_q + 1'b1;
    end

    assign pos_o = pos_q;

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pos_q) < FRAME_LEN); // R1
    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != '0) |-> (pos_q == $past(pos_q) + 1'b1)); // R1
    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == LAST) |=> (pos_q == '0)); // R1
endmodule

// File: rtl/fseq_prog_ram.sv
module fseq_prog_ram #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic                        lock_i,
    input  logic [AW-1:0]               waddr_i,
    input  logic [fseq_pkg::WORD_W-1:0] wdata_i,
    input  logic [AW-1:0]               raddr_i,
    output logic [fseq_pkg::WORD_W-1:0] rdata_o
);
    logic [fseq_pkg::WORD_W-1:0] mem_q [DEPTH];
    logic                        accept;

    assign accept = we_i && !lock_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else if (accept) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && lock_i) |=> (mem_q[$past(waddr_i)] == $past(mem_q[waddr_i]))); // R9
    AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !lock_i) |=> (mem_q[$past(waddr_i)] == $past(wdata_i))); // R9
endmodule

// File: rtl/fseq_core.sv
module fseq_core
    import fseq_pkg::*;
#(
    parameter int AW    = 5,
    parameter int CNT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  pos_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [AW-1:0]     pc_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              wr_en_o,
    output logic [RADR_W-1:0] wr_addr_o,
    output logic [RDAT_W-1:0] wr_data_o
);
    seq_state_t        state_q, state_d;
    logic [AW-1:0]     pc_q, pc_d;
    seq_op_t           op;
    logic [TGT_W-1:0]  target;
    logic              hit;

    // Word decode
    assign op     = classify(word_i);
    assign target = word_i[TGT_W-1:0];
    assign hit    = (32'(pos_i) == 32'(target));

    // Next-state and program-counter logic
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = S_RUN;
                    pc_d    = '0;
                end
            end
            S_RUN: begin
                unique case (op)
                    OP_END:  state_d = S_IDLE;
                    OP_MOVE: pc_d = pc_q + 1'b1;
                    OP_HOLD: begin
                        if (hit)
                            pc_d = pc_q + 1'b1;
                        else
                            state_d = S_HOLD;
                    end
                    default: state_d = S_IDLE;
                endcase
            end
            S_HOLD: begin
                if (hit) begin
                    state_d = S_RUN;
                    pc_d    = pc_q + 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            done_o    <= 1'b0;
        end else begin
            wr_en_o <= (state_q == S_RUN) && (op == OP_MOVE);
            done_o  <= (state_q == S_RUN) && (op == OP_END);
            if ((state_q == S_RUN) && (op == OP_MOVE)) begin
                wr_addr_o <= word_i[RDAT_W +: RADR_W];
                wr_data_o <= word_i[RDAT_W-1:0];
            end
        end
    end

    assign busy_o = (state_q != S_IDLE);
    assign pc_o   = pc_q;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_HOLD) && !hit) |=> $stable(pc_q)); // R3
    AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o); // R4
    AST_DONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R5
    AST_NO_WR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && done_o)); // R5
    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && start_i) |=> (busy_o && (pc_q == '0))); // R10
endmodule

// File: rtl/qb_scenario_seq.sv
module qb_scenario_seq #(
    parameter int FRAME_LEN = 5000,
    parameter int DEPTH     = 32,
    parameter int CNT_W     = $clog2(FRAME_LEN),
    parameter int AW        = $clog2(DEPTH)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                prog_we,
    input  logic [AW-1:0]                       prog_addr,
    input  logic [fseq_pkg::WORD_W-1:0]         prog_wdata,
    input  logic                                start,
    output logic [CNT_W-1:0]                    frame_pos,
    output logic                                busy,
    output logic                                done,
    output logic                                wr_en,
    output logic [fseq_pkg::RADR_W-1:0]         wr_addr,
    output logic [fseq_pkg::RDAT_W-1:0]         wr_data
);
    logic [AW-1:0]               pc;
    logic [fseq_pkg::WORD_W-1:0] word;

    fseq_frame_ctr #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .pos_o (frame_pos)
    );

    fseq_prog_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (prog_we),
        .lock_i  (busy),
        .waddr_i (prog_addr),
        .wdata_i (prog_wdata),
        .raddr_i (pc),
        .rdata_o (word)
    );

    fseq_core #(.AW(AW), .CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .pos_i     (frame_pos),
        .word_i    (word),
        .pc_o      (pc),
        .busy_o    (busy),
        .done_o    (done),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );
endmodule

// File: tb/sim_qb_scenario_seq.sv
module sim_qb_scenario_seq;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 5000;
    localparam int AWD = 5;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        prog_we = 0;
    logic [AWD-1:0] prog_addr = '0;
    logic [15:0] prog_wdata = '0;
    logic        start = 0;
    logic [12:0] frame_pos;
    logic        busy, done, wr_en;
    logic [6:0]  wr_addr;
    logic [7:0]  wr_data;

    qb_scenario_seq u0 (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .start(start), .frame_pos(frame_pos),
        .busy(busy), .done(done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_total = 0, n_fail = 0, cyc = 0;
    logic [15:0] prog [32];
    int plen;
    int got_t[64], got_p[64], got_a[64], got_d[64], n_got;
    int exp_t[64], exp_p[64], exp_a[64], exp_d[64], n_exp;
    int done_t, exp_done_t, start_cyc;
    bit collecting = 0, done_seen = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (collecting) begin
            if (wr_en && n_got < 64) begin
                got_t[n_got] = cyc - start_cyc;
                got_p[n_got] = int'(frame_pos);
                got_a[n_got] = int'(wr_addr);
                got_d[n_got] = int'(wr_data);
                n_got++;
            end
            if (done) begin
                done_seen = 1;
                done_t = cyc - start_cyc;
                collecting = 0;
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    function automatic logic [15:0] mv(input int a, input int d);
        return 16'h8000 | 16'((a & 8'h7f) << 8) | 16'(d & 8'hff);
    endfunction

    function automatic logic [15:0] hold(input int tgt);
        return 16'h2000 | 16'(tgt & 13'h1fff);
    endfunction

    // Timing model built from R3, R4, R5, R8: t counts cycles since the start cycle
    task automatic predict(input int s);
        int t = 1;
        n_exp = 0;
        for (int pc = 0; pc < 32; pc++) begin
            logic [15:0] w = prog[pc];
            if (w == 16'h0) begin
                exp_done_t = t + 1;
                return;
            end else if (w[15]) begin
                exp_t[n_exp] = t + 1;
                exp_p[n_exp] = (s + t + 1) % N;
                exp_a[n_exp] = int'(w[14:8]);
                exp_d[n_exp] = int'(w[7:0]);
                n_exp++;
                t++;
            end else begin
                while (((s + t) % N) != int'(w[12:0])) t++;
                t++;
            end
        end
    endtask

    task automatic load();
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            prog_we = 1; prog_addr = AWD'(i); prog_wdata = prog[i];
        end
        @(negedge clk);
        prog_we = 0;
    endtask

    task automatic run(input string req, input bit poke);
        int s;
        @(negedge clk);
        start = 1; s = int'(frame_pos); start_cyc = cyc;
        n_got = 0; done_seen = 0; collecting = 1;
        @(negedge clk);
        start = 0;
        chk("R10", "busy after start", int'(busy), 1);
        if (poke) begin
            // R9: overwrite every word while the run is in progress
            for (int i = 0; i < 32; i++) begin
                prog_we = 1; prog_addr = AWD'(i); prog_wdata = 16'h80ff ^ 16'(i * 7);
                @(negedge clk);
            end
            prog_we = 0;
        end
        while (!done_seen) @(negedge clk);
        predict(s);
        chk(req, "strobe count", n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            chk(req, "strobe time", got_t[i], exp_t[i]);
            chk(req, "strobe pos", got_p[i], exp_p[i]);
            chk("R2", "strobe addr", got_a[i], exp_a[i]);
            chk("R2", "strobe data", got_d[i], exp_d[i]);
        end
        chk("R5", "done time", done_t, exp_done_t);
        chk("R5", "busy after done", int'(busy), 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R10", "busy in reset", int'(busy), 0);
        chk("R10", "wr_en in reset", int'(wr_en), 0);
        chk("R1", "pos in reset", int'(frame_pos), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "pos after first edge", int'(frame_pos), 1);
        chk("R10", "done idle", int'(done), 0);

        // R8 + R4: immediate moves
        prog[0] = mv(5, 8'h11); prog[1] = mv(127, 8'hff); prog[2] = mv(0, 8'h01);
        prog[3] = 16'h0; plen = 4;
        load();
        run("R8", 0);

        // R6: hold target after wrap
        prog[0] = hold(4998); prog[1] = mv(1, 8'hA0); prog[2] = mv(2, 8'hA1);
        prog[3] = hold(63); prog[4] = mv(3, 8'hA2); prog[5] = 16'h0; plen = 6;
        load();
        run("R6", 0);
        chk("R6", "post-wrap strobe pos", got_p[2], 65);

        // R7: repeated holds at 0 each take a frame
        prog[0] = hold(0); prog[1] = hold(0); prog[2] = mv(9, 8'h3C);
        prog[3] = 16'h0; plen = 4;
        load();
        run("R7", 0);
        chk("R7", "strobe at pos 2", got_p[0], 2);
        chk("R7", "second hold waited a frame", int'(got_t[0] > N), 1);

        // R1: explicit wrap observation
        while (frame_pos != 13'(N - 1)) @(negedge clk);
        @(negedge clk);
        chk("R1", "wrap to zero", int'(frame_pos), 0);

        // R9: writes while busy ignored; replay must match
        prog[0] = hold(300); prog[1] = mv(4, 8'h55); prog[2] = mv(6, 8'h66);
        prog[3] = 16'h0; plen = 4;
        load();
        run("R9", 1);
        run("R9", 0);

        // R3 + R4 + R2: random programs
        for (int k = 0; k < 6; k++) begin
            int len = 1 + ($urandom % 12);
            int holds = 0;
            for (int i = 0; i < len; i++) begin
                if (holds < 2 && ($urandom % 5) == 0) begin
                    prog[i] = hold($urandom % N) | 16'(($urandom % 4) << 13);
                    holds++;
                end else begin
                    prog[i] = mv($urandom % 128, $urandom % 256);
                end
            end
            prog[len] = 16'h0; plen = len + 1;
            load();
            run("R3", 0);
        end
        summary();
    end
endmodule